// File: doc/BRIEF.md
# BCD Calendar Clock with Masked Alarm

This block is the timekeeping core of a real-time clock. It holds seconds, minutes, hours, day of month, month and a two-digit year, each as one packed-BCD byte. The core advances by one second on each one-cycle pulse of `sec_tick`, but only while its run bit is set. The one-second pulse comes from a prescaler outside the block. Carries ripple from seconds up to the year. Day-of-month limits follow the month, and February has 29 days in every year divisible by four. The year covers only 00 to 99, so a single century can be represented.

Software reaches the core through a byte-wide register port with a combinational read path.

- **Time:** software can read or overwrite any time field at any moment.
- **Alarm compare:** software can load a compare value per field.
- **Alarm enables:** each field has its own match enable. Clearing a field's enable makes that field a wildcard. A global enable gates the alarm interrupt.
- **Pending bits:** a pending register keeps separate alarm and tick bits, and each bit is cleared by writing a 1 to it.

A whole-set rollover happens at a single clock edge. Software that reads seconds as 00 should therefore read the set again.

Top module: `bcd_rtc_core`

Register map (4-bit address):

| Address | Contents |
|---|---|
| 0 | Control. Bit 0 is run; bit 1 is tick interrupt enable. |
| 1 | Alarm control. Bit 0 is the global enable. Bits 1 to 6 are the match enables for second, minute, hour, day, month and year. |
| 2 | Pending. Bit 0 is alarm; bit 1 is tick. Writing a 1 clears the bit. |
| 3 | Reads 00. |
| 4 to 9 | Time: second, minute, hour, day, month, year. |
| 10 to 15 | Alarm compare values, in the same field order as the time registers. |

## Requirements
- R1: Reset (synchronous, `rst_n` low at a clock edge) sets the time to 00:00:00, day 01, month 01, year 00. It clears control, alarm control, all alarm compare values and both pending bits, and drives both interrupt outputs low.
- R2: A write to any control, alarm-control, time or alarm-compare address is visible on `rdata` from the next cycle. `rdata` is combinational on `addr`.
- R3: A `sec_tick` pulse increments the BCD seconds only when run (control bit 0) is set. With run clear, the time registers do not change.
- R4: Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00 and carry into the day.
- R5: A day carry past 30 (months 04, 06, 09, 11) or past 31 (all other months except 02) sets the day to 01 and carries into the month.
- R6: In month 02, the day wraps after 29 when the year value is divisible by four (including 00), and after 28 otherwise.
- R7: Month is 1-based and wraps from 12 to 01 with a carry into the year. The year wraps from 99 to 00.
- R8: On each advancing tick, the updated time is compared with the alarm values. The alarm pending bit (pending bit 0) is set when every field whose match enable is set is equal, and at least one match enable is set. Fields whose enable is clear are ignored.
- R9: `alarm_irq` is high exactly while the alarm pending bit and the global alarm enable (alarm control bit 0) are both set. The pending bit is set on a match even when the global enable is clear.
- R10: Writing the pending register clears each bit written as 1. A bit written as 0 keeps its value. A set in the same cycle wins over a clear.
- R11: Every advancing tick sets the tick pending bit (pending bit 1). A tick while stopped does not set it. `tick_irq` is the tick pending bit gated by control bit 1.
- R12: A write to a time register in the same cycle as an advancing tick stores the written value in that field. The other fields still advance from their old values, and a carry into the written field is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address, for both read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| alarm_irq | output | 1 | Alarm interrupt |
| tick_irq | output | 1 | Per-second tick interrupt |

## Verification
The bench builds the core with its default `ADDR_W` of 4. This makes all sixteen addresses reachable, including the unused one and the full block of alarm compare registers.

A table of preset times, each followed by one tick, drives the carry chain through:
- every month-length class;
- both February lengths, across leap and common years;
- the end-of-century wrap.

Directed cases then cover:
- wildcard and mismatched alarm fields;
- a pending bit set while the global enable is off;
- write-one-to-clear behaviour;
- a time write that collides with a tick;
- a second reset while the clock is running.

// File: rtl/rtc_pkg.sv
// rtc_pkg: shared constants and BCD helpers for the calendar clock.
// Assumes all time values are valid packed BCD; field index 0 is seconds
// and index 5 is the year.
package rtc_pkg;

    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 6;

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DAY  = 3;
    localparam int F_MON  = 4;
    localparam int F_YEAR = 5;

    localparam int A_CTRL    = 0;
    localparam int A_ALMCTL  = 1;
    localparam int A_PEND    = 2;
    localparam int A_TIME0   = 4;
    localparam int A_ALM0    = A_TIME0 + NUM_FIELDS;

    typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0] rtc_fields_t;

    // Add one to a packed-BCD byte (caller handles the field limit).
    function automatic logic [FIELD_W-1:0] bcd_inc(input logic [FIELD_W-1:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return v + 8'd1;
    endfunction

    // Last day of a month in BCD; February leaps when year % 4 == 0.
    function automatic logic [FIELD_W-1:0] month_last_day(input logic [FIELD_W-1:0] mon,
                                                         input logic [FIELD_W-1:0] yr);
        int ybin;
        ybin = int'(yr[7:4]) * 10 + int'(yr[3:0]);
        case (mon)
            8'h02:                      return ((ybin % 4) == 0) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_advance.sv
// rtc_advance: combinational one-second step of the BCD calendar.
// When step is high, seconds increment and carries ripple through
// minute, hour, day (month-length aware), month and year. When step is
// low, the output equals the input. Assumes the current time is valid BCD.
module rtc_advance
    import rtc_pkg::*;
(
    input  rtc_fields_t cur,
    input  logic        step,
    output rtc_fields_t nxt
);

    localparam logic [2:0][FIELD_W-1:0] LOW_LIMITS = {8'h23, 8'h59, 8'h59};

    logic carry;

    // Ripple the carry from seconds to year.
    always_comb begin
        nxt   = cur;
        carry = step;
        for (int i = 0; i < 3; i++) begin
            if (carry) begin
                if (cur[i] >= LOW_LIMITS[i]) begin
                    nxt[i] = '0;
                end else begin
                    nxt[i] = bcd_inc(cur[i]);
                    carry  = 1'b0;
                end
            end
        end
        if (carry) begin
            if (cur[F_DAY] >= month_last_day(cur[F_MON], cur[F_YEAR])) begin
                nxt[F_DAY] = 8'h01;
            end else begin
                nxt[F_DAY] = bcd_inc(cur[F_DAY]);
                carry      = 1'b0;
            end
        end
        if (carry) begin
            if (cur[F_MON] >= 8'h12) begin
                nxt[F_MON] = 8'h01;
            end else begin
                nxt[F_MON] = bcd_inc(cur[F_MON]);
                carry      = 1'b0;
            end
        end
        if (carry) begin
            if (cur[F_YEAR] >= 8'h99)
                nxt[F_YEAR] = 8'h00;
            else
                nxt[F_YEAR] = bcd_inc(cur[F_YEAR]);
        end
    end

endmodule

// File: rtl/rtc_alarm_cmp.sv
// rtc_alarm_cmp: masked equality of the time against the alarm values.
// A field with its enable clear acts as a wildcard. The hit output needs
// at least one enabled field, so an all-wildcard setting never fires.
module rtc_alarm_cmp
    import rtc_pkg::*;
(
    input  rtc_fields_t           cur,
    input  rtc_fields_t           alm,
    input  logic [NUM_FIELDS-1:0] field_en,
    output logic                  hit
);

    logic [NUM_FIELDS-1:0] field_ok;

    // One comparator per field.
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
        assign field_ok[g] = !field_en[g] || (cur[g] == alm[g]);
    end

    // All enabled fields agree and at least one is enabled.
    assign hit = (&field_ok) && (|field_en);

endmodule

// File: rtl/bcd_rtc_core.sv
// bcd_rtc_core: BCD calendar clock with a masked alarm and a byte register
// port. It advances one second per sec_tick while run is set, compares
// the advanced time with the alarm values, and keeps write-one-to-clear
// pending bits for alarm and tick. Assumes sec_tick is a single-cycle
// pulse synchronous to clk. Reset is synchronous and active low.
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              alarm_irq,
    output logic              tick_irq
);

    localparam int ALMCTL_W = NUM_FIELDS + 1;

    localparam rtc_fields_t TIME_RESET = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    rtc_fields_t         time_q;
    rtc_fields_t         time_nxt;
    rtc_fields_t         alm_q;
    logic                run_q;
    logic                tick_en_q;
    logic [ALMCTL_W-1:0] almctl_q;
    logic                pend_alarm_q;
    logic                pend_tick_q;
    logic                step;
    logic                hit;
    logic                wr_pend;

    assign step    = sec_tick && run_q;
    assign wr_pend = wr_en && (addr == ADDR_W'(A_PEND));

    rtc_advance u_adv (
        .cur  (time_q),
        .step (step),
        .nxt  (time_nxt)
    );

    rtc_alarm_cmp u_cmp (
        .cur      (time_nxt),
        .alm      (alm_q),
        .field_en (almctl_q[ALMCTL_W-1:1]),
        .hit      (hit)
    );

    // Time fields: a software write wins over the advance for its own field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= TIME_RESET;
        end else begin
            for (int i = 0; i < NUM_FIELDS; i++) begin
                if (wr_en && (addr == ADDR_W'(A_TIME0 + i)))
                    time_q[i] <= wdata;
                else
                    time_q[i] <= time_nxt[i];
            end
        end
    end

    // Alarm compare values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_q <= '0;
        end else begin
            for (int i = 0; i < NUM_FIELDS; i++) begin
                if (wr_en && (addr == ADDR_W'(A_ALM0 + i)))
                    alm_q[i] <= wdata;
            end
        end
    end

    // Control and alarm-control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            tick_en_q <= 1'b0;
            almctl_q  <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(A_CTRL)) begin
                run_q     <= wdata[0];
                tick_en_q <= wdata[1];
            end
            if (addr == ADDR_W'(A_ALMCTL))
                almctl_q <= wdata[ALMCTL_W-1:0];
        end
    end

    // Pending bits: set on an event, cleared by writing one; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_alarm_q <= 1'b0;
            pend_tick_q  <= 1'b0;
        end else begin
            if (step && hit)
                pend_alarm_q <= 1'b1;
            else if (wr_pend && wdata[0])
                pend_alarm_q <= 1'b0;
            if (step)
                pend_tick_q <= 1'b1;
            else if (wr_pend && wdata[1])
                pend_tick_q <= 1'b0;
        end
    end

    // Combinational read mux.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_CTRL))   rdata = {6'b0, tick_en_q, run_q};
        if (addr == ADDR_W'(A_ALMCTL)) rdata = 8'(almctl_q);
        if (addr == ADDR_W'(A_PEND))   rdata = {6'b0, pend_tick_q, pend_alarm_q};
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (addr == ADDR_W'(A_TIME0 + i)) rdata = time_q[i];
            if (addr == ADDR_W'(A_ALM0 + i))  rdata = alm_q[i];
        end
    end

    // Interrupt outputs.
    assign alarm_irq = pend_alarm_q && almctl_q[0];
    assign tick_irq  = pend_tick_q && tick_en_q;

    // A stopped clock with no writes keeps its time.
    assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr_en) |=> $stable(time_q));

    // Seconds at 59 on an advancing tick wrap to 00.
    assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_en && time_q[F_SEC] == 8'h59) |=> (time_q[F_SEC] == 8'h00));

    // The alarm interrupt rises only after a tick or a register write.
    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_irq) |-> $past(sec_tick || wr_en));

    // Writing one to the alarm pending bit clears it when no tick collides.
    assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pend && wdata[0] && !step) |=> !pend_alarm_q);

    // Every advancing tick leaves the tick pending bit set.
    assert_tick_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> pend_tick_q);

endmodule

// File: tb/bcd_rtc_core_tb_top.sv
// Bench for bcd_rtc_core: a carry-chain vector table, then directed tests.
module bcd_rtc_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sec_tick;
    logic       wr_en;
    logic [3:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       alarm_irq;
    logic       tick_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    bcd_rtc_core #(.ADDR_W(4)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .alarm_irq (alarm_irq),
        .tick_irq  (tick_irq)
    );

    // Each entry: {time before, time after one tick}, fields {yr,mon,day,hr,min,sec}.
    localparam int NVEC = 12;
    localparam logic [95:0] VEC [NVEC] = '{
        {48'h00_01_01_00_00_00, 48'h00_01_01_00_00_01},  // R3 plain step
        {48'h00_01_01_00_00_09, 48'h00_01_01_00_00_10},  // R3 BCD digit carry
        {48'h00_01_01_23_59_59, 48'h00_01_02_00_00_00},  // R4 full day carry
        {48'h00_01_01_09_59_59, 48'h00_01_01_10_00_00},  // R4 hour digit carry
        {48'h00_04_30_23_59_59, 48'h00_05_01_00_00_00},  // R5 30-day month
        {48'h00_05_30_23_59_59, 48'h00_05_31_00_00_00},  // R5 31-day month, no wrap
        {48'h00_01_31_23_59_59, 48'h00_02_01_00_00_00},  // R5 31-day month wrap
        {48'h00_11_30_23_59_59, 48'h00_12_01_00_00_00},  // R5 November
        {48'h23_02_28_23_59_59, 48'h23_03_01_00_00_00},  // R6 common year
        {48'h24_02_28_23_59_59, 48'h24_02_29_00_00_00},  // R6 leap year
        {48'h24_02_29_23_59_59, 48'h24_03_01_00_00_00},  // R6 leap day wrap
        {48'h99_12_31_23_59_59, 48'h00_01_01_00_00_00}   // R7 century wrap
    };
    localparam int VEC_REQ [NVEC] = '{3, 3, 4, 4, 5, 5, 5, 5, 6, 6, 6, 7};

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic set_time(input logic [47:0] t);
        for (int i = 0; i < 6; i++) wr(4'(4 + i), t[8*i +: 8]);
    endtask

    task automatic chk_time(input logic [47:0] t, input string tag);
        for (int i = 0; i < 6; i++) rd_chk(4'(4 + i), t[8*i +: 8], tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sec_tick = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        do_reset();

        // R1 reset state
        chk_time(48'h00_01_01_00_00_00, "R1 time reset");
        rd_chk(4'd0, 8'h00, "R1 ctrl reset");
        rd_chk(4'd1, 8'h00, "R1 alarm ctrl reset");
        rd_chk(4'd2, 8'h00, "R1 pending reset");
        rd_chk(4'd10, 8'h00, "R1 alarm sec reset");
        check("R1 alarm_irq reset", 8'(alarm_irq), 8'h00);
        check("R1 tick_irq reset", 8'(tick_irq), 8'h00);

        // R3 / R11: stopped clock ignores ticks
        set_time(48'h00_01_01_00_00_05);
        pulse_tick();
        chk_time(48'h00_01_01_00_00_05, "R3 stopped hold");
        rd_chk(4'd2, 8'h00, "R11 no tick pend while stopped");

        // R2 readback
        wr(4'd0, 8'h01);
        rd_chk(4'd0, 8'h01, "R2 ctrl readback");
        wr(4'd15, 8'h42);
        rd_chk(4'd15, 8'h42, "R2 alarm year readback");
        rd_chk(4'd3, 8'h00, "R2 unused address");

        // Vector table: R3 R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            set_time(VEC[v][95:48]);
            pulse_tick();
            chk_time(VEC[v][47:0], $sformatf("R%0d vector %0d", VEC_REQ[v], v));
        end

        // R8 / R9: matching alarm with one wildcard field
        wr(4'd2, 8'h03);
        wr(4'd10, 8'h59); wr(4'd11, 8'h20); wr(4'd12, 8'h05);
        wr(4'd1, 8'h07);                  // global, sec, min (hour wildcard)
        set_time(48'h00_01_01_10_20_58);
        pulse_tick();
        rd_chk(4'd2, 8'h03, "R8 alarm and tick pending");
        check("R9 alarm_irq on", 8'(alarm_irq), 8'h01);
        check("R11 tick_irq gated", 8'(tick_irq), 8'h00);

        // R10 write-one-to-clear
        wr(4'd2, 8'h00);
        rd_chk(4'd2, 8'h03, "R10 zero write keeps");
        wr(4'd2, 8'h01);
        rd_chk(4'd2, 8'h02, "R10 clear alarm only");
        check("R9 alarm_irq off after clear", 8'(alarm_irq), 8'h00);
        wr(4'd0, 8'h03);
        check("R11 tick_irq enabled", 8'(tick_irq), 8'h01);
        wr(4'd2, 8'h02);
        check("R10 tick cleared", 8'(tick_irq), 8'h00);

        // R8 enabled mismatching field blocks the alarm
        wr(4'd1, 8'h0F);
        set_time(48'h00_01_01_10_20_58);
        pulse_tick();
        rd_chk(4'd2, 8'h02, "R8 hour mismatch");

        // R9 pending sets with global enable off; irq waits for enable
        wr(4'd2, 8'h03);
        wr(4'd1, 8'h06);
        set_time(48'h00_01_01_10_20_58);
        pulse_tick();
        rd_chk(4'd2, 8'h03, "R9 pending without global");
        check("R9 irq low without global", 8'(alarm_irq), 8'h00);
        wr(4'd1, 8'h07);
        check("R9 irq after global set", 8'(alarm_irq), 8'h01);

        // R8 no field enables: never matches
        wr(4'd2, 8'h03);
        wr(4'd1, 8'h01);
        set_time(48'h00_01_01_10_20_58);
        pulse_tick();
        rd_chk(4'd2, 8'h02, "R8 all wildcards no alarm");

        // R12 write colliding with a tick
        set_time(48'h00_01_01_00_05_59);
        @(negedge clk);
        sec_tick = 1'b1; wr_en = 1'b1; addr = 4'd5; wdata = 8'h20;
        @(negedge clk);
        sec_tick = 1'b0; wr_en = 1'b0;
        chk_time(48'h00_01_01_00_20_00, "R12 write wins over carry");

        // R1 reset while running
        wr(4'd2, 8'h03);
        pulse_tick();
        do_reset();
        chk_time(48'h00_01_01_00_00_00, "R1 second reset");
        rd_chk(4'd2, 8'h00, "R1 pending after second reset");
        rd_chk(4'd12, 8'h00, "R1 alarm hour after second reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule